// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the mode keeper of an on-chip clock generator. Software picks a reference (internal or external) and a clock source (the locked loop output, or the reference driven straight through). From those two selections and two qualifiers, it decides which of seven operating modes is in force each cycle. The qualifiers are a debug-enable flag and a low-power flag. When both the loop is bypassed and the low-power flag is set while debug is off, it picks the low-power variant of the bypass, in which the loop is shut down.

A synchronous stop request parks the block in a stop mode from any other mode. The mode that was in force is remembered and restored when the request drops. An asynchronous reset always lands in the default mode, which discards any remembered mode. The outputs are a 3-bit mode code, a one-hot flag per mode, a loop-enable strobe and a select for the clock driven onto the bus.

Beside the mode logic sits an oscillator-ready bit. It counts reference cycles while the external oscillator is selected and in use, and it sets once a programmable start-up count has elapsed.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the mode code is 0, only mode flag 0 is set, loop_en is 1, bus_src is 00 and osc_rdy is 0.
- R2: With halt_req low and not in stop, ref_int=1 with src_sel=00 gives mode 0 (loop engaged, internal) at the next edge, and ref_int=0 with src_sel=00 gives mode 1 (loop engaged, external).
- R3: ref_int=1 with src_sel=01 gives mode 2 (internal bypass) when dbg_en=1 or lp_req=0, and mode 3 (internal bypass, low power) when dbg_en=0 and lp_req=1.
- R4: ref_int=0 with src_sel=10 gives mode 4 (external bypass) when dbg_en=1 or lp_req=0, and mode 5 (external bypass, low power) when dbg_en=0 and lp_req=1.
- R5: src_sel=11, and the pairs ref_int=0/src_sel=01 and ref_int=1/src_sel=10, leave the mode unchanged.
- R6: halt_req sampled high at an edge puts the block in mode 6 (stop) from any mode, and it stays there while halt_req stays high.
- R7: The mode in force on the edge that enters stop is saved. At the first edge with halt_req low in stop, the block returns to that saved mode, and the selections apply again from the following edge.
- R8: A reset asserted while in stop leaves the block in mode 0 after release, and the mode saved before reset is not restored.
- R9: Exactly one bit of mode_flags is set, at the index equal to the mode code.
- R10: loop_en is 1 only in modes 0 and 1. bus_src is 00 in modes 0 and 1, 01 in modes 2 and 3, 10 in modes 4 and 5, and 11 in stop.
- R11: The enable condition is osc_sel=1 together with either ext_ref_en=1 or a mode of 1, 4 or 5. osc_rdy rises after the edge that completes OSC_INIT_CYCLES consecutive edges with the condition true.
- R12: At the first edge where the enable condition is false, osc_rdy and the count clear. A later start counts a full OSC_INIT_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_int | input | 1 | Reference select: 1 internal, 0 external |
| src_sel | input | 2 | Clock source select |
| dbg_en | input | 1 | Debug enabled flag |
| lp_req | input | 1 | Low-power flag for bypass modes |
| halt_req | input | 1 | Stop request, sampled on clk |
| ext_ref_en | input | 1 | External reference enable |
| osc_sel | input | 1 | External oscillator selected |
| mode_code | output | 3 | Current mode, 0 to 6 |
| mode_flags | output | 7 | One-hot mode flags |
| loop_en | output | 1 | Loop running |
| bus_src | output | 2 | Bus clock source select |
| osc_rdy | output | 1 | Oscillator start-up complete |

## Verification
The bench goes after the stop round trip from a low-power bypass mode. A design that saved the mode one cycle late, or re-decoded on exit, would come back in the wrong variant. It toggles the qualifiers while in a bypass mode, which exposes an inverted debug or low-power term as a wrong variant. It also feeds reserved and mismatched select pairs, which a loose decoder would turn into a mode change. Reset inside stop must not bring back the saved mode. The ready counter is checked one edge before and at the terminal count, and it is broken mid-count to catch a counter that resumes instead of restarting.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
   localparam int MODE_W    = 3;
   localparam int NUM_MODES = 7;

   typedef enum logic [MODE_W-1:0] {
      M_ENG_INT    = 3'd0,
      M_ENG_EXT    = 3'd1,
      M_BYP_INT    = 3'd2,
      M_BYP_INT_LP = 3'd3,
      M_BYP_EXT    = 3'd4,
      M_BYP_EXT_LP = 3'd5,
      M_HALT       = 3'd6
   } mode_e;

   localparam logic [1:0] SRC_LOOP = 2'b00;
   localparam logic [1:0] SRC_INT  = 2'b01;
   localparam logic [1:0] SRC_EXT  = 2'b10;
   localparam logic [1:0] SRC_OFF  = 2'b11;

   function automatic logic uses_ext(input mode_e m);
      return (m == M_ENG_EXT) || (m == M_BYP_EXT) || (m == M_BYP_EXT_LP);
   endfunction
endpackage

// File: rtl/clksrc_sel_decode.sv
module clksrc_sel_decode
   import clksrc_pkg::*;
(
   input  logic       ref_int,
   input  logic [1:0] src_sel,
   input  logic       dbg_en,
   input  logic       lp_req,
   input  mode_e      cur_mode,
   output mode_e      sel_mode
);
   logic lp_ok;

   always_comb begin
      lp_ok    = !dbg_en && lp_req;
      sel_mode = cur_mode;
      unique case ({ref_int, src_sel})
         3'b100:  sel_mode = M_ENG_INT;
         3'b000:  sel_mode = M_ENG_EXT;
         3'b101:  sel_mode = lp_ok ? M_BYP_INT_LP : M_BYP_INT;
         3'b010:  sel_mode = lp_ok ? M_BYP_EXT_LP : M_BYP_EXT;
         default: sel_mode = cur_mode;
      endcase
   end
endmodule

// File: rtl/clksrc_mode_seq.sv
module clksrc_mode_seq
   import clksrc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  halt_req,
   input  mode_e sel_mode,
   output mode_e mode_q,
   output mode_e saved_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_ENG_INT;
         saved_q <= M_ENG_INT;
      end else if (halt_req) begin
         if (mode_q != M_HALT) saved_q <= mode_q;
         mode_q <= M_HALT;
      end else if (mode_q == M_HALT) begin
         mode_q <= saved_q;
      end else begin
         mode_q <= sel_mode;
      end
   end

   p_halt_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> mode_q == M_HALT);
   p_halt_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && mode_q != M_HALT) |=> saved_q == $past(mode_q));
   p_halt_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && mode_q == M_HALT) |=> mode_q == $past(saved_q));
   p_reserved_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && mode_q != M_HALT && src_sel_is_hold) |=> $stable(mode_q));

   logic src_sel_is_hold;
   assign src_sel_is_hold = (sel_mode == mode_q);
endmodule

// File: rtl/clksrc_out_map.sv
module clksrc_out_map
   import clksrc_pkg::*;
(
   input  mode_e                  mode_q,
   output logic [MODE_W-1:0]      mode_code,
   output logic [NUM_MODES-1:0]   mode_flags,
   output logic                   loop_en,
   output logic [1:0]             bus_src
);
   assign mode_code = mode_q;

   for (genvar i = 0; i < NUM_MODES; i++) begin : g_flag
      assign mode_flags[i] = (mode_q == mode_e'(i));
   end

   always_comb begin
      loop_en = 1'b0;
      bus_src = SRC_OFF;
      case (mode_q)
         M_ENG_INT, M_ENG_EXT: begin
            loop_en = 1'b1;
            bus_src = SRC_LOOP;
         end
         M_BYP_INT, M_BYP_INT_LP: bus_src = SRC_INT;
         M_BYP_EXT, M_BYP_EXT_LP: bus_src = SRC_EXT;
         default: bus_src = SRC_OFF;
      endcase
   end

   always_comb begin
      a_onehot_r9: assert ($countones(mode_flags) == 1 || mode_q > M_HALT);
   end
endmodule

// File: rtl/clksrc_osc_ready.sv
module clksrc_osc_ready
   import clksrc_pkg::*;
#(
   parameter int OSC_INIT_CYCLES = 4096
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  osc_sel,
   input  logic  ext_ref_en,
   input  mode_e mode_q,
   output logic  osc_rdy
);
   localparam int CNT_W = (OSC_INIT_CYCLES > 1) ? $clog2(OSC_INIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSC_INIT_CYCLES - 1);

   if (OSC_INIT_CYCLES < 1) begin : g_bad_cfg
      $error("OSC_INIT_CYCLES must be at least 1");
   end

   logic run;
   assign run = osc_sel && (ext_ref_en || uses_ext(mode_q));

   if (OSC_INIT_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   osc_rdy <= 1'b0;
         else          osc_rdy <= run;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            osc_rdy <= 1'b0;
         end else if (!run) begin
            cnt_q   <= '0;
            osc_rdy <= 1'b0;
         end else if (!osc_rdy) begin
            if (cnt_q == CNT_LAST) osc_rdy <= 1'b1;
            else                   cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   p_rdy_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !osc_rdy);
   p_rdy_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_rdy) |-> $past(run));
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
   import clksrc_pkg::*;
#(
   parameter int OSC_INIT_CYCLES = 4096
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_int,
   input  logic [1:0] src_sel,
   input  logic       dbg_en,
   input  logic       lp_req,
   input  logic       halt_req,
   input  logic       ext_ref_en,
   input  logic       osc_sel,
   output logic [2:0] mode_code,
   output logic [6:0] mode_flags,
   output logic       loop_en,
   output logic [1:0] bus_src,
   output logic       osc_rdy
);
   mode_e sel_mode, mode_q, saved_q;

   clksrc_sel_decode u_dec (
      .ref_int(ref_int), .src_sel(src_sel), .dbg_en(dbg_en), .lp_req(lp_req),
      .cur_mode(mode_q), .sel_mode(sel_mode));

   clksrc_mode_seq u_seq (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sel_mode(sel_mode),
      .mode_q(mode_q), .saved_q(saved_q));

   clksrc_out_map u_map (
      .mode_q(mode_q), .mode_code(mode_code), .mode_flags(mode_flags),
      .loop_en(loop_en), .bus_src(bus_src));

   clksrc_osc_ready #(.OSC_INIT_CYCLES(OSC_INIT_CYCLES)) u_osc (
      .clk(clk), .rst_n(rst_n), .osc_sel(osc_sel), .ext_ref_en(ext_ref_en),
      .mode_q(mode_q), .osc_rdy(osc_rdy));

   p_loop_only_engaged_r10: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (mode_code <= 3'd1));
   p_stop_gates_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd6) |-> (bus_src == 2'b11 && !loop_en));
   p_lp_needs_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(halt_req) && $past(mode_code) != 3'd6 && $changed(mode_code)
       && (mode_code == 3'd3 || mode_code == 3'd5)) |-> ($past(lp_req) && !$past(dbg_en)));
endmodule

// File: tb/sim_clksrc_mode_ctrl.sv
module sim_clksrc_mode_ctrl;
   localparam int PERIOD = 10;
   localparam int NCYC   = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_int = 1'b1, dbg_en = 1'b0, lp_req = 1'b0, halt_req = 1'b0;
   logic ext_ref_en = 1'b0, osc_sel = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic [2:0] mode_code;
   logic [6:0] mode_flags;
   logic loop_en, osc_rdy;
   logic [1:0] bus_src;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   clksrc_mode_ctrl #(.OSC_INIT_CYCLES(NCYC)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_int(ref_int), .src_sel(src_sel),
      .dbg_en(dbg_en), .lp_req(lp_req), .halt_req(halt_req),
      .ext_ref_en(ext_ref_en), .osc_sel(osc_sel), .mode_code(mode_code),
      .mode_flags(mode_flags), .loop_en(loop_en), .bus_src(bus_src),
      .osc_rdy(osc_rdy));

   typedef struct packed {
      logic r; logic [1:0] s; logic d; logic l; logic h; logic [2:0] m;
   } vec_t;

   // ref, src, dbg, lp, halt, expected mode
   localparam vec_t VEC [0:20] = '{
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0},   // R2
      '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1},   // R2
      '{1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd1},   // R5
      '{1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 3'd2},   // R3
      '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 3'd3},   // R3
      '{1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 3'd2},   // R3
      '{1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'd2},   // R5
      '{1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 3'd4},   // R4
      '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 3'd5},   // R4
      '{1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 3'd6},   // R6
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 3'd6},   // R6
      '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 3'd5},   // R7
      '{1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 3'd5},   // R5
      '{1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 3'd4},   // R4
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0},   // R2
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 3'd6},   // R6
      '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 3'd0},   // R7
      '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 3'd3},   // R3
      '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 3'd6},   // R6
      '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd3},   // R7 saved mode first
      '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1}    // R7 selections apply next
   };

   function automatic logic [1:0] exp_bus(input logic [2:0] m);
      if (m <= 3'd1) return 2'b00;
      if (m <= 3'd3) return 2'b01;
      if (m <= 3'd5) return 2'b10;
      return 2'b11;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_mode(input string tag, input logic [2:0] m);
      chk({tag, " mode"}, 32'(mode_code), 32'(m));
      chk("R9 flags", 32'(mode_flags), 32'(7'(1) << m));
      chk("R10 loop_en", 32'(loop_en), 32'(m <= 3'd1));
      chk("R10 bus_src", 32'(bus_src), 32'(exp_bus(m)));
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(PERIOD*200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #(PERIOD*2 + 1);
      chk_mode("R1 in reset", 3'd0);
      chk("R1 osc_rdy", 32'(osc_rdy), 0);
      @(negedge clk); rst_n = 1'b1;
      edges(1);
      chk_mode("R1 after release", 3'd0);

      for (int i = 0; i < 21; i++) begin
         ref_int = VEC[i].r; src_sel = VEC[i].s; dbg_en = VEC[i].d;
         lp_req = VEC[i].l; halt_req = VEC[i].h;
         edges(1);
         chk_mode("R2/R3/R4/R5/R6/R7 table", VEC[i].m);
      end

      // R8: reset inside stop drops the saved mode
      ref_int = 1'b0; src_sel = 2'b10; dbg_en = 1'b0; lp_req = 1'b1; halt_req = 1'b0;
      edges(1);
      chk_mode("R4 pre-stop", 3'd5);
      halt_req = 1'b1; edges(1);
      chk_mode("R6 stop", 3'd6);
      src_sel = 2'b11;
      rst_n = 1'b0; edges(1);
      chk_mode("R8 reset in stop", 3'd0);
      halt_req = 1'b0; rst_n = 1'b1; edges(2);
      chk_mode("R8 no restore", 3'd0);

      // R11: ready after NCYC edges
      osc_sel = 1'b1; ext_ref_en = 1'b1;
      edges(NCYC - 1);
      chk("R11 not yet", 32'(osc_rdy), 0);
      edges(1);
      chk("R11 ready", 32'(osc_rdy), 1);
      // R12: clear on enable drop
      ext_ref_en = 1'b0; edges(1);
      chk("R12 cleared", 32'(osc_rdy), 0);
      // R11: external mode alone enables counting
      osc_sel = 1'b0; ref_int = 1'b0; src_sel = 2'b00; edges(1);
      chk_mode("R2 ext engaged", 3'd1);
      osc_sel = 1'b1; edges(10);
      osc_sel = 1'b0; edges(1);
      chk("R12 broken count", 32'(osc_rdy), 0);
      osc_sel = 1'b1; edges(NCYC - 1);
      chk("R12 restart not yet", 32'(osc_rdy), 0);
      edges(1);
      chk("R11 ext mode ready", 32'(osc_rdy), 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule